// File: doc/BRIEF.md
# Bus Request Arbiter

This block decides which of up to sixteen bus masters may drive the next address phase on a shared high-speed system bus. Each master raises a request line, and the arbiter answers with a one-hot grant vector. A single configuration input chooses the scheme at run time: either a fixed ranking, in which a lower index always wins, or a rotating scheme that starts its search just after the master that last held the bus. When nobody is asking, the bus is parked on a default master. Under the fixed scheme that is master 0. Under the rotating scheme it is whichever master held the bus last.

The arbiter changes the grant only on a clock edge where the bus-ready input is high, so a transfer that is being stretched is never cut off. A granted master that raises its lock line, and keeps requesting, holds the bus until it drops the lock. When a slave answers the current owner with a split response, that master is masked out of arbitration until the slave raises the master's bit on the split-resume vector. If every master that is requesting is masked, the bus goes to an internal dummy master that issues only idle transfers. The owner outputs give the master index, the dummy flag and the lock flag for the address phase in progress. They follow the grant one ready edge later.

Internally a grant state machine has four states. PARK means the bus sits on the default master. BUSY means the bus belongs to a requesting master chosen by the picker. LOCK means a locked owner is being held. DUMMY means every requester is masked. On each ready edge the state machine takes the first of these transitions that applies:
- Any state other than DUMMY goes to LOCK when its owner is locked, requesting and unmasked.
- Any state goes to BUSY when an unmasked requester exists.
- Any state goes to DUMMY when requesters exist but all of them are masked.
- Any state goes to PARK otherwise.

On an edge where ready is low, every state holds.

Top module: `bus_arbiter`

## Requirements
- R1: The grant output is always one-hot, except while the dummy flag is high, when the grant is all zeros.
- R2: The grant and the dummy flag change only on a clock edge where ready is high.
- R3: With the mode input at 0 (fixed), the lowest-index requesting unmasked master is granted.
- R4: With the mode input at 1 (rotating), the search starts at the index one above the last granted master, wrapping from the highest index to 0.
- R5: With mode 0 and no request, the bus is parked on master 0.
- R6: With mode 1 and no request, the bus stays parked on the last granted master.
- R7: While the granted master keeps both its lock and request bits high and is not masked, the grant does not move, even if higher-ranked masters request.
- R8: A split response pulse during a non-dummy address phase masks the current owner from the next edge onward, and a masked master is never granted while it requests.
- R9: A bit of the split-resume vector clears that master's mask on the next edge, and resume wins over a simultaneous split.
- R10: If at least one master requests and every requester is masked, the dummy flag goes high and no master is granted.
- R11: On each ready edge, the owner index, the owner dummy flag and the owner lock flag take the grant index, the dummy flag and the lock bit of the granted master as they stood before that edge.
- R12: After reset, master 0 is granted, the owner index is 0, both dummy flags and the owner lock flag are low, and no master is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Bus request, one bit per master |
| lock_i | input | N_MST | Locked-sequence request, one bit per master |
| mode_rr_i | input | 1 | 0 selects fixed ranking, 1 selects rotating |
| ready_i | input | 1 | Bus ready; the grant may change only when this is high |
| split_rsp_i | input | 1 | Pulse: the current owner received a split response |
| split_resume_i | input | N_MST | Per-master split resume, which unmasks the master |
| grant_o | output | N_MST | One-hot bus grant |
| dummy_o | output | 1 | The bus is given to the idle dummy master |
| owner_o | output | OWN_W | Index of the master owning the current address phase |
| owner_dummy_o | output | 1 | The current address phase belongs to the dummy master |
| owner_lock_o | output | 1 | The current address phase is part of a locked sequence |

## Verification
Some properties hold on every cycle, and the assertions check them continuously:
- the grant is one-hot or cleared together with the dummy flag;
- nothing moves on an edge where ready is low;
- a locked owner is held;
- a masked requester is never chosen;
- the fixed scheme never skips a lower eligible index;
- mask bits set and clear on the right edges;
- the owner outputs trail the grant.

The rotating search order, the parking choice in each mode, and the hand-off from DUMMY back to a real master after resume depend on a history of several cycles. Only the bench's vector walk and directed split and lock scenarios can show those.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [1:0] {
        ST_PARK  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_LOCK  = 2'd2,
        ST_DUMMY = 2'd3
    } arb_state_e;

endpackage

// File: rtl/arb_picker.sv
module arb_picker #(
    parameter int N_MST = 16,
    parameter int IDW   = 4
) (
    input  logic [N_MST-1:0] elig_i,
    input  logic             mode_rr_i,
    input  logic [IDW-1:0]   last_i,
    output logic             found_o,
    output logic [IDW-1:0]   pick_o
);

    // Scan all masters once, starting at 0 (fixed) or last+1 (rotating).
    always_comb begin
        int start;
        found_o = 1'b0;
        pick_o  = '0;
        start   = mode_rr_i ? (int'(last_i) + 1) : 0;
        if (start >= N_MST) begin
            start = 0;
        end
        for (int k = 0; k < N_MST; k++) begin
            int cand;
            cand = start + k;
            if (cand >= N_MST) begin
                cand = cand - N_MST;
            end
            if (!found_o && elig_i[IDW'(cand)]) begin
                found_o = 1'b1;
                pick_o  = IDW'(cand);
            end
        end
    end

endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
    parameter int N_MST = 16,
    parameter int IDW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             split_rsp_i,
    input  logic [IDW-1:0]   owner_i,
    input  logic             owner_dummy_i,
    input  logic [N_MST-1:0] resume_i,
    output logic [N_MST-1:0] mask_o
);

    logic [N_MST-1:0] set_w;

    always_comb begin
        set_w = '0;
        if (split_rsp_i && !owner_dummy_i) begin
            set_w[owner_i] = 1'b1;
        end
    end

    for (genvar i = 0; i < N_MST; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[i] <= 1'b0;
            end else if (resume_i[i]) begin
                mask_o[i] <= 1'b0;
            end else if (set_w[i]) begin
                mask_o[i] <= 1'b1;
            end
        end

        AST_SPLIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (set_w[i] && !resume_i[i]) |=> mask_o[i]); // R8
        AST_RESUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            resume_i[i] |=> !mask_o[i]); // R9
    end

endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import arb_pkg::*;
#(
    parameter int N_MST = 16,
    parameter int IDW   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] lock_i,
    input  logic [N_MST-1:0] mask_i,
    input  logic             mode_rr_i,
    input  logic             ready_i,
    input  logic             found_i,
    input  logic [IDW-1:0]   pick_i,
    output logic [N_MST-1:0] elig_o,
    output logic [IDW-1:0]   gidx_o,
    output logic [N_MST-1:0] grant_o,
    output logic             dummy_o
);

    arb_state_e     state_q, state_d;
    logic [IDW-1:0] gidx_q, gidx_d;
    logic           hold_lock;
    logic           pend_masked;

    assign elig_o      = req_i & ~mask_i;
    assign pend_masked = |(req_i & mask_i);
    assign hold_lock   = (state_q != ST_DUMMY) && lock_i[gidx_q]
                         && req_i[gidx_q] && !mask_i[gidx_q];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PARK;
            gidx_q  <= '0;
        end else begin
            state_q <= state_d;
            gidx_q  <= gidx_d;
        end
    end

    // Next state
    always_comb begin
        arb_state_e     free_st;
        logic [IDW-1:0] free_idx;
        if (found_i) begin
            free_st  = ST_BUSY;
            free_idx = pick_i;
        end else if (pend_masked) begin
            free_st  = ST_DUMMY;
            free_idx = gidx_q;
        end else begin
            free_st  = ST_PARK;
            free_idx = mode_rr_i ? gidx_q : '0;
        end
        state_d = state_q;
        gidx_d  = gidx_q;
        if (ready_i) begin
            unique case (state_q)
                ST_DUMMY: begin
                    state_d = free_st;
                    gidx_d  = free_idx;
                end
                ST_PARK, ST_BUSY, ST_LOCK: begin
                    if (hold_lock) begin
                        state_d = ST_LOCK;
                    end else begin
                        state_d = free_st;
                        gidx_d  = free_idx;
                    end
                end
                default: begin
                    state_d = ST_PARK;
                    gidx_d  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        grant_o = '0;
        dummy_o = 1'b0;
        unique case (state_q)
            ST_DUMMY: dummy_o = 1'b1;
            ST_PARK, ST_BUSY, ST_LOCK: grant_o[gidx_q] = 1'b1;
            default: dummy_o = 1'b0;
        endcase
    end

    assign gidx_o = gidx_q;

    AST_GRANT_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ($onehot(grant_o) && !dummy_o) || (dummy_o && grant_o == '0)); // R1
    AST_STILL_WHEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> ($stable(grant_o) && $stable(dummy_o))); // R2
    AST_FIXED_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !mode_rr_i && !hold_lock && found_i)
        |=> (((grant_o - {{(N_MST-1){1'b0}}, 1'b1}) & $past(elig_o)) == '0)); // R3
    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && hold_lock) |=> $stable(grant_o)); // R7
    AST_NO_MASKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !hold_lock) |=> ((grant_o & $past(req_i & mask_i)) == '0)); // R8
    AST_DUMMY_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !hold_lock && !found_i && pend_masked) |=> dummy_o); // R10

endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
    parameter int N_MST = 16,
    parameter int OWN_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] req_i,
    input  logic [N_MST-1:0] lock_i,
    input  logic             mode_rr_i,
    input  logic             ready_i,
    input  logic             split_rsp_i,
    input  logic [N_MST-1:0] split_resume_i,
    output logic [N_MST-1:0] grant_o,
    output logic             dummy_o,
    output logic [OWN_W-1:0] owner_o,
    output logic             owner_dummy_o,
    output logic             owner_lock_o
);

    logic [N_MST-1:0] mask_w;
    logic [N_MST-1:0] elig_w;
    logic             found_w;
    logic [OWN_W-1:0] pick_w;
    logic [OWN_W-1:0] gidx_w;

    arb_split_mask #(.N_MST(N_MST), .IDW(OWN_W)) u_mask (
        .clk           (clk),
        .rst_n         (rst_n),
        .split_rsp_i   (split_rsp_i),
        .owner_i       (owner_o),
        .owner_dummy_i (owner_dummy_o),
        .resume_i      (split_resume_i),
        .mask_o        (mask_w)
    );

    arb_picker #(.N_MST(N_MST), .IDW(OWN_W)) u_pick (
        .elig_i    (elig_w),
        .mode_rr_i (mode_rr_i),
        .last_i    (gidx_w),
        .found_o   (found_w),
        .pick_o    (pick_w)
    );

    arb_grant_fsm #(.N_MST(N_MST), .IDW(OWN_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .lock_i    (lock_i),
        .mask_i    (mask_w),
        .mode_rr_i (mode_rr_i),
        .ready_i   (ready_i),
        .found_i   (found_w),
        .pick_i    (pick_w),
        .elig_o    (elig_w),
        .gidx_o    (gidx_w),
        .grant_o   (grant_o),
        .dummy_o   (dummy_o)
    );

    // Address-phase owner, one ready edge behind the grant
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_o       <= '0;
            owner_dummy_o <= 1'b0;
            owner_lock_o  <= 1'b0;
        end else if (ready_i) begin
            owner_o       <= gidx_w;
            owner_dummy_o <= dummy_o;
            owner_lock_o  <= lock_i[gidx_w] && !dummy_o;
        end
    end

    AST_OWNER_DUMMY_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ready_i |=> (owner_dummy_o == $past(dummy_o))); // R11
    AST_OWNER_WAS_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && !dummy_o) |=> ((($past(grant_o)) >> owner_o) & {{(N_MST-1){1'b0}}, 1'b1}) != '0); // R11

endmodule

// File: tb/sim_bus_arbiter.sv
module sim_bus_arbiter;

    localparam int N = 4;
    localparam int W = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic [N-1:0] lock = '0;
    logic         mode_rr = 1'b0;
    logic         ready = 1'b1;
    logic         split_rsp = 1'b0;
    logic [N-1:0] resume = '0;
    logic [N-1:0] grant;
    logic         dummy;
    logic [W-1:0] owner;
    logic         owner_dummy;
    logic         owner_lock;

    int errors = 0;
    int checks = 0;

    bus_arbiter #(.N_MST(N)) u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_i          (req),
        .lock_i         (lock),
        .mode_rr_i      (mode_rr),
        .ready_i        (ready),
        .split_rsp_i    (split_rsp),
        .split_resume_i (resume),
        .grant_o        (grant),
        .dummy_o        (dummy),
        .owner_o        (owner),
        .owner_dummy_o  (owner_dummy),
        .owner_lock_o   (owner_lock)
    );

    always #10 clk = ~clk;

    // Vector fields: [13:10] req, [9:6] lock, [5] mode, [4] ready, [3:0] expected grant
    localparam logic [13:0] VEC [15] = '{
        {4'b0110, 4'b0000, 1'b0, 1'b1, 4'b0010}, // R3 lowest requester
        {4'b0110, 4'b0000, 1'b0, 1'b1, 4'b0010}, // R3 stays
        {4'b0000, 4'b0000, 1'b0, 1'b1, 4'b0001}, // R5 park on 0
        {4'b1010, 4'b0000, 1'b1, 1'b1, 4'b0010}, // R4 search from 1
        {4'b1010, 4'b0000, 1'b1, 1'b1, 4'b1000}, // R4 next after 1
        {4'b1010, 4'b0000, 1'b1, 1'b1, 4'b0010}, // R4 wraps
        {4'b0000, 4'b0000, 1'b1, 1'b1, 4'b0010}, // R6 park on last
        {4'b0001, 4'b0000, 1'b1, 1'b0, 4'b0010}, // R2 ready low holds
        {4'b0001, 4'b0000, 1'b1, 1'b1, 4'b0001}, // R4 wrap to 0
        {4'b1100, 4'b0000, 1'b0, 1'b1, 4'b0100}, // R3
        {4'b1101, 4'b0100, 1'b0, 1'b1, 4'b0100}, // R7 locked owner kept
        {4'b1101, 4'b0000, 1'b0, 1'b1, 4'b0001}, // R3 after unlock
        {4'b1111, 4'b0000, 1'b0, 1'b1, 4'b0001}, // R3
        {4'b1111, 4'b0000, 1'b1, 1'b1, 4'b0010}, // R4
        {4'b1111, 4'b0000, 1'b1, 1'b1, 4'b0100}  // R4
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req = '0; lock = '0; mode_rr = 1'b0; ready = 1'b1;
        split_rsp = 1'b0; resume = '0;
        step();
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        check("R12 grant", 16'(grant), 16'h1);
        check("R12 owner", 16'(owner), 16'h0);
        check("R12 dummy", 16'(dummy), 16'h0);
        check("R12 owner dummy", 16'(owner_dummy), 16'h0);
        check("R12 owner lock", 16'(owner_lock), 16'h0);

        for (int v = 0; v < 15; v++) begin
            req     = VEC[v][13:10];
            lock    = VEC[v][9:6];
            mode_rr = VEC[v][5];
            ready   = VEC[v][4];
            step();
            check($sformatf("vector %0d grant", v), 16'(grant), 16'(VEC[v][3:0]));
            check($sformatf("vector %0d R1 dummy", v), 16'(dummy), 16'h0);
        end

        // Owner trails grant, then split masking
        do_reset();
        req = 4'b0010;
        step();
        check("R11 owner before", 16'(owner), 16'h0);
        step();
        check("R11 owner after", 16'(owner), 16'h1);
        split_rsp = 1'b1;
        step();
        split_rsp = 1'b0;
        check("R8 grant same edge", 16'(grant), 16'h2);
        step();
        check("R10 grant", 16'(grant), 16'h0);
        check("R10 dummy", 16'(dummy), 16'h1);
        step();
        check("R11 owner dummy", 16'(owner_dummy), 16'h1);
        req = 4'b0011;
        step();
        check("R8 masked skipped", 16'(grant), 16'h1);
        req = 4'b0010;
        step();
        check("R10 again", 16'(dummy), 16'h1);
        resume = 4'b0010;
        step();
        resume = '0;
        check("R9 edge of resume", 16'(dummy), 16'h1);
        step();
        check("R9 unmasked grant", 16'(grant), 16'h2);

        // Locked owner
        req = 4'b0100;
        lock = 4'b0100;
        step();
        check("R7 grant", 16'(grant), 16'h4);
        step();
        check("R11 owner idx", 16'(owner), 16'h2);
        check("R11 owner lock", 16'(owner_lock), 16'h1);
        req = 4'b0101;
        step();
        check("R7 held vs master 0", 16'(grant), 16'h4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule